// File: doc/BRIEF.md
# Interval Timer Bus Register Front End

This block is the byte-wide host side of a three-channel interval timer. A host reaches it through a 2-bit address, an 8-bit write bus, an 8-bit read bus and separate read and write strobes. Address 3 takes command bytes. A command byte can program a channel, freeze a channel's count, or capture a snapshot of count and status for several channels in one write. Addresses 0 to 2 reach each channel's count register. Initial counts are written there one or two bytes at a time, and count values are read back from there.

The counting engines sit outside this block. For each channel the block drives an operating mode, a 16-bit initial count and a one-cycle load strobe. It receives each channel's live count and output level. A read returns, in fixed order of precedence, a pending status snapshot, then a frozen count, then the live count. Each channel keeps its own byte order state for loads and for reads.

Top module: `itmr_bus_regs`

## Requirements
- R1: Addresses 0, 1 and 2 reach the count registers of channels 0, 1 and 2. Address 3 takes command bytes, and a read of address 3 returns 0x00. When rd_en and wr_en are both high in a cycle, the read is ignored.
- R2: A command byte decodes as [7:6] channel, [5:4] byte access (1 low byte, 2 high byte, 3 low then high), [3:1] operating mode and [0] decimal flag. With a nonzero access and a channel of 0 to 2, the byte sets that channel's access and flag and drives the mode onto ch_mode[3i+2:3i] from the next cycle.
- R3: In access 1, a write to a count address sets the channel's count to {0x00, byte} and raises that channel's ch_load bit for one cycle, starting the cycle after the write strobe.
- R4: In access 2, a write sets the count to {byte, 0x00} and pulses ch_load in the same way.
- R5: In access 3, the first data byte is held and does not load. The second byte loads {second, first} and pulses ch_load.
- R6: A command byte that programs a channel returns both that channel's write byte order and its read byte order to the low byte.
- R7: A command byte whose access field is 0 freezes the live count of the named channel. While a frozen count is still unread, a further freeze of that channel is ignored.
- R8: A frozen count is read as low then high byte in access 3 and is released after the high byte. In access 1 or 2 it gives the one selected byte and is released after that read.
- R9: With no status and no frozen count pending, a count read returns the live low byte in access 1, the live high byte in access 2, and in access 3 it alternates low and high, starting from the low byte.
- R10: A command byte with channel field 3 is a snapshot command. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 low freezes the count and bit 4 low captures the status of every selected channel.
- R11: A status byte is {output level, 0, access[1:0], mode[2:0], decimal flag}, taken at the snapshot edge. A status that has not been read is not replaced by a later capture.
- R12: A read returns a pending status first and clears it. Otherwise it returns a frozen count, and otherwise the live count.
- R13: rdata is registered. It shows the selected byte from the cycle after the read strobe and holds between reads. At most one ch_load bit is high in any cycle.
- R14: During and after reset, every channel has mode 3, access 3 and count 0, no load is pending, and rdata is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 2 | Register address: 0 to 2 for channel counts, 3 for commands |
| wdata | input | 8 | Write data byte |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| rdata | output | 8 | Registered read data |
| ch_mode | output | 9 | Operating mode of each channel, 3 bits per channel |
| ch_count | output | 48 | Initial count of each channel, 16 bits per channel |
| ch_load | output | 3 | One-cycle count load pulse per channel |
| ch_live | input | 48 | Live count from each channel's counting engine |
| ch_out | input | 3 | Output level of each channel |

## Verification
The bench builds the block with its default of three channels. This makes every select bit of the snapshot command live, and it leaves address 3 as the only address with no channel behind it. With all channels present, one snapshot can hit all three at once, each in a different access mode. The test then checks status priority, single-byte release of a frozen count and two-byte release of a frozen count in one sequence. The bench drives the live counts and output levels directly, so it can change them between a freeze and its readout. This shows which value was captured and when.

// File: rtl/itmr_regif_pkg.sv
package itmr_regif_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = 2 * BYTE_W;
  localparam int unsigned MODE_W = 3;
  localparam int unsigned ADDR_W = 2;

  // byte access selector; XF_NONE doubles as "nothing frozen"
  typedef enum logic [1:0] {
    XF_NONE = 2'd0,
    XF_LO   = 2'd1,
    XF_HI   = 2'd2,
    XF_WORD = 2'd3
  } xfer_e;

endpackage

// File: rtl/itmr_cmd_decode.sv
module itmr_cmd_decode
  import itmr_regif_pkg::*;
#(
  parameter int unsigned NCH = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic              rd_go,
  output logic [NCH-1:0]    cfg_wr,
  output logic [NCH-1:0]    latch_req,
  output logic [NCH-1:0]    stat_req,
  output logic [NCH-1:0]    data_wr,
  output logic [NCH-1:0]    data_rd,
  output xfer_e             cfg_acc,
  output logic [MODE_W-1:0] cfg_mode,
  output logic              cfg_bcd
);

  localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(3);
  localparam logic [1:0]        SNAP_SEL = 2'd3;

  logic       is_cmd;
  logic       is_snap;
  logic [1:0] ch_sel;

  assign ch_sel   = wdata[7:6];
  assign is_cmd   = wr_en && (addr == CMD_ADDR);
  assign is_snap  = (ch_sel == SNAP_SEL);
  assign rd_go    = rd_en && !wr_en;
  assign cfg_acc  = xfer_e'(wdata[5:4]);
  assign cfg_mode = wdata[3:1];
  assign cfg_bcd  = wdata[0];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit;
    logic snap_pick;
    assign hit        = is_cmd && !is_snap && (ch_sel == 2'(i));
    assign snap_pick  = is_cmd && is_snap && wdata[i+1];
    assign cfg_wr[i]    = hit && (cfg_acc != XF_NONE);
    assign latch_req[i] = (hit && (cfg_acc == XF_NONE)) || (snap_pick && !wdata[5]);
    assign stat_req[i]  = snap_pick && !wdata[4];
    assign data_wr[i]   = wr_en && (addr == ADDR_W'(i));
    assign data_rd[i]   = rd_go && (addr == ADDR_W'(i));
  end

endmodule

// File: rtl/itmr_chan_regs.sv
module itmr_chan_regs
  import itmr_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              cfg_wr,
  input  xfer_e             cfg_acc,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic              cfg_bcd,
  input  logic              latch_req,
  input  logic              stat_req,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [CNT_W-1:0]  live_cnt,
  input  logic              out_lvl,
  output logic [MODE_W-1:0] mode_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              load_o,
  output logic              wr_phase_o,
  output logic [BYTE_W-1:0] rd_byte_o
);

  xfer_e             acc_q, acc_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              bcd_q, bcd_d;
  logic              wr_hi_q, wr_hi_d;
  logic              rd_hi_q, rd_hi_d;
  logic [BYTE_W-1:0] hold_q, hold_d;
  logic [CNT_W-1:0]  frz_q, frz_d;
  xfer_e             frz_st_q, frz_st_d;
  logic [BYTE_W-1:0] stat_q, stat_d;
  logic              stat_vld_q, stat_vld_d;
  logic [CNT_W-1:0]  count_q, count_d;
  logic              load_q, load_d;
  logic              st_en;

  assign st_en = cfg_wr | data_wr | data_rd | latch_req | stat_req;

  // next state
  always_comb begin
    acc_d      = acc_q;
    mode_d     = mode_q;
    bcd_d      = bcd_q;
    wr_hi_d    = wr_hi_q;
    rd_hi_d    = rd_hi_q;
    hold_d     = hold_q;
    frz_d      = frz_q;
    frz_st_d   = frz_st_q;
    stat_d     = stat_q;
    stat_vld_d = stat_vld_q;
    count_d    = count_q;
    load_d     = 1'b0;

    if (cfg_wr) begin
      acc_d   = cfg_acc;
      mode_d  = cfg_mode;
      bcd_d   = cfg_bcd;
      wr_hi_d = 1'b0;
      rd_hi_d = 1'b0;
    end

    if (data_wr) begin
      unique case (acc_q)
        XF_LO: begin
          count_d = {{BYTE_W{1'b0}}, wdata};
          load_d  = 1'b1;
        end
        XF_HI: begin
          count_d = {wdata, {BYTE_W{1'b0}}};
          load_d  = 1'b1;
        end
        XF_WORD: begin
          if (!wr_hi_q) begin
            hold_d  = wdata;
            wr_hi_d = 1'b1;
          end else begin
            count_d = {wdata, hold_q};
            load_d  = 1'b1;
            wr_hi_d = 1'b0;
          end
        end
        default: ;
      endcase
    end

    if (latch_req && (frz_st_q == XF_NONE)) begin
      frz_d    = live_cnt;
      frz_st_d = acc_q;
    end

    if (stat_req && !stat_vld_q) begin
      stat_d     = {out_lvl, 1'b0, acc_q, mode_q, bcd_q};
      stat_vld_d = 1'b1;
    end

    if (data_rd) begin
      if (stat_vld_q) begin
        stat_vld_d = 1'b0;
      end else if (frz_st_q != XF_NONE) begin
        frz_st_d = (frz_st_q == XF_WORD) ? XF_HI : XF_NONE;
      end else if (acc_q == XF_WORD) begin
        rd_hi_d = !rd_hi_q;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q      <= XF_WORD;
      mode_q     <= MODE_W'(3);
      bcd_q      <= 1'b0;
      wr_hi_q    <= 1'b0;
      rd_hi_q    <= 1'b0;
      hold_q     <= '0;
      frz_q      <= '0;
      frz_st_q   <= XF_NONE;
      stat_q     <= '0;
      stat_vld_q <= 1'b0;
    end else if (st_en) begin
      acc_q      <= acc_d;
      mode_q     <= mode_d;
      bcd_q      <= bcd_d;
      wr_hi_q    <= wr_hi_d;
      rd_hi_q    <= rd_hi_d;
      hold_q     <= hold_d;
      frz_q      <= frz_d;
      frz_st_q   <= frz_st_d;
      stat_q     <= stat_d;
      stat_vld_q <= stat_vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      load_q  <= 1'b0;
    end else begin
      load_q <= load_d;
      if (load_d) count_q <= count_d;
    end
  end

  // byte presented to the read port, by priority
  always_comb begin
    if (stat_vld_q) begin
      rd_byte_o = stat_q;
    end else if (frz_st_q != XF_NONE) begin
      rd_byte_o = (frz_st_q == XF_HI) ? frz_q[CNT_W-1:BYTE_W] : frz_q[BYTE_W-1:0];
    end else begin
      unique case (acc_q)
        XF_HI:   rd_byte_o = live_cnt[CNT_W-1:BYTE_W];
        XF_WORD: rd_byte_o = rd_hi_q ? live_cnt[CNT_W-1:BYTE_W] : live_cnt[BYTE_W-1:0];
        default: rd_byte_o = live_cnt[BYTE_W-1:0];
      endcase
    end
  end

  assign mode_o     = mode_q;
  assign count_o    = count_q;
  assign load_o     = load_q;
  assign wr_phase_o = wr_hi_q;

endmodule

// File: rtl/itmr_rd_port.sv
module itmr_rd_port
  import itmr_regif_pkg::*;
#(
  parameter int unsigned NCH = 3
) (
  input  logic                        clk,
  input  logic                        rst_ni,
  input  logic                        rd_go,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [NCH-1:0][BYTE_W-1:0]  rd_bytes,
  output logic [BYTE_W-1:0]           rdata
);

  logic [BYTE_W-1:0] sel_byte;
  logic [BYTE_W-1:0] rdata_q, rdata_d;

  always_comb begin
    sel_byte = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr == ADDR_W'(i)) sel_byte = rd_bytes[i];
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_go) rdata_d = sel_byte;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/itmr_bus_regs.sv
module itmr_bus_regs
  import itmr_regif_pkg::*;
#(
  parameter int unsigned NCH = 3
) (
  input  logic                  clk,
  input  logic                  rst_ni,
  input  logic [1:0]            addr,
  input  logic [7:0]            wdata,
  input  logic                  wr_en,
  input  logic                  rd_en,
  output logic [7:0]            rdata,
  output logic [NCH*3-1:0]      ch_mode,
  output logic [NCH*16-1:0]     ch_count,
  output logic [NCH-1:0]        ch_load,
  input  logic [NCH*16-1:0]     ch_live,
  input  logic [NCH-1:0]        ch_out
);

  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic                       rd_go;
  logic [NCH-1:0]             cfg_wr, latch_req, stat_req, data_wr, data_rd;
  xfer_e                      cfg_acc;
  logic [MODE_W-1:0]          cfg_mode;
  logic                       cfg_bcd;
  logic [NCH-1:0][BYTE_W-1:0] rd_bytes;
  logic [NCH-1:0]             wr_phase;

  itmr_cmd_decode #(.NCH(NCH)) u_dec (
    .addr      (addr),
    .wdata     (wdata),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rd_go     (rd_go),
    .cfg_wr    (cfg_wr),
    .latch_req (latch_req),
    .stat_req  (stat_req),
    .data_wr   (data_wr),
    .data_rd   (data_rd),
    .cfg_acc   (cfg_acc),
    .cfg_mode  (cfg_mode),
    .cfg_bcd   (cfg_bcd)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    itmr_chan_regs u_chan (
      .clk        (clk),
      .rst_ni     (rst_sync_n),
      .cfg_wr     (cfg_wr[i]),
      .cfg_acc    (cfg_acc),
      .cfg_mode   (cfg_mode),
      .cfg_bcd    (cfg_bcd),
      .latch_req  (latch_req[i]),
      .stat_req   (stat_req[i]),
      .data_wr    (data_wr[i]),
      .data_rd    (data_rd[i]),
      .wdata      (wdata),
      .live_cnt   (ch_live[i*CNT_W +: CNT_W]),
      .out_lvl    (ch_out[i]),
      .mode_o     (ch_mode[i*MODE_W +: MODE_W]),
      .count_o    (ch_count[i*CNT_W +: CNT_W]),
      .load_o     (ch_load[i]),
      .wr_phase_o (wr_phase[i]),
      .rd_byte_o  (rd_bytes[i])
    );
  end

  itmr_rd_port #(.NCH(NCH)) u_rd (
    .clk      (clk),
    .rst_ni   (rst_sync_n),
    .rd_go    (rd_go),
    .addr     (addr),
    .rd_bytes (rd_bytes),
    .rdata    (rdata)
  );

endmodule

// File: rtl/itmr_bus_regs_chk.sv
module itmr_bus_regs_chk #(
  parameter int unsigned NCH = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       addr,
  input logic             wr_en,
  input logic             rd_en,
  input logic [7:0]       rdata,
  input logic [NCH*3-1:0] ch_mode,
  input logic [NCH-1:0]   ch_load,
  input logic [NCH-1:0]   cfg_wr,
  input logic [NCH-1:0]   wr_phase
);

  // R13: loads never overlap
  assert_load_onehot_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_load));

  // R13: read data holds when no read strobe
  assert_rdata_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  // R1: command address reads back zero
  assert_cmd_read_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == 2'd3) |=> (rdata == 8'h00));

  // R2: mode outputs only move after a command byte
  assert_mode_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ch_mode) |-> $past(wr_en && addr == 2'd3));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    // R3: a load follows a data write to that channel
    assert_load_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ch_load[i] |-> $past(wr_en && addr == 2'(i)));

    // R6: programming a channel rewinds its write byte order
    assert_toggle_rewind_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr[i] |=> !wr_phase[i]);
  end

endmodule

bind itmr_bus_regs itmr_bus_regs_chk #(.NCH(NCH)) u_itmr_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .addr     (addr),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .rdata    (rdata),
  .ch_mode  (ch_mode),
  .ch_load  (ch_load),
  .cfg_wr   (cfg_wr),
  .wr_phase (wr_phase)
);

// File: tb/test_itmr_bus_regs.sv
module test_itmr_bus_regs;

  localparam int NCH = 3;

  logic            clk = 1'b0;
  logic            rst_ni;
  logic [1:0]      addr;
  logic [7:0]      wdata;
  logic            wr_en, rd_en;
  logic [7:0]      rdata;
  logic [NCH*3-1:0]  ch_mode;
  logic [NCH*16-1:0] ch_count;
  logic [NCH-1:0]    ch_load;
  logic [NCH*16-1:0] ch_live;
  logic [NCH-1:0]    ch_out;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  itmr_bus_regs #(.NCH(NCH)) i_itmr_bus_regs (
    .clk(clk), .rst_ni(rst_ni), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .ch_mode(ch_mode),
    .ch_count(ch_count), .ch_load(ch_load), .ch_live(ch_live), .ch_out(ch_out)
  );

  // {is_write, addr, data, expected read byte}
  localparam int NV = 22;
  localparam logic [18:0] VEC [NV] = '{
    {1'b1, 2'd3, 8'h34, 8'h00},  // ch0 word access, mode 2 (R2)
    {1'b0, 2'd0, 8'h00, 8'h34},  // R9 live low
    {1'b0, 2'd0, 8'h00, 8'h12},  // R9 live high
    {1'b0, 2'd0, 8'h00, 8'h34},  // R9 low again
    {1'b1, 2'd3, 8'h00, 8'h00},  // R7 freeze ch0
    {1'b0, 2'd0, 8'h00, 8'h34},  // R8 frozen low
    {1'b0, 2'd0, 8'h00, 8'h12},  // R8 frozen high, released
    {1'b0, 2'd0, 8'h00, 8'h12},  // R9 live keeps its own order
    {1'b1, 2'd3, 8'h52, 8'h00},  // ch1 low access, mode 1
    {1'b0, 2'd1, 8'h00, 8'hCD},  // R9 low only
    {1'b0, 2'd1, 8'h00, 8'hCD},  // R9 no toggling
    {1'b1, 2'd3, 8'h40, 8'h00},  // R7 freeze ch1
    {1'b0, 2'd1, 8'h00, 8'hCD},  // R8
    {1'b0, 2'd1, 8'h00, 8'hCD},  // R8
    {1'b1, 2'd3, 8'hA7, 8'h00},  // ch2 high access, mode 3, flag 1
    {1'b0, 2'd2, 8'h00, 8'h5A},  // R9 high only
    {1'b0, 2'd3, 8'h00, 8'h00},  // R1 command address reads zero
    {1'b1, 2'd3, 8'hC8, 8'h00},  // R10 snapshot ch2 count+status
    {1'b0, 2'd2, 8'h00, 8'hA7},  // R11 status byte
    {1'b0, 2'd2, 8'h00, 8'h5A},  // R12 frozen after status
    {1'b0, 2'd2, 8'h00, 8'h5A},  // R12 live last
    {1'b0, 2'd0, 8'h00, 8'h34}   // R9
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [1:0] a, output logic [7:0] b);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    b = rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R13 actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [18:0] v;
    rst_ni = 1'b0; addr = '0; wdata = '0; wr_en = 1'b0; rd_en = 1'b0;
    ch_live = {16'h5A69, 16'hABCD, 16'h1234};
    ch_out  = 3'b101;
    repeat (3) @(negedge clk);
    // R14 in reset
    chk("R14 mode in reset", 32'(ch_mode), 32'h0DB);
    chk("R14 rdata in reset", 32'(rdata), 32'h0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk("R14 count after reset", 32'(ch_count[31:0]), 32'h0);
    chk("R14 load after reset", 32'(ch_load), 32'h0);
    chk("R14 mode after reset", 32'(ch_mode), 32'h0DB);

    for (int k = 0; k < NV; k++) begin
      v = VEC[k];
      if (v[18]) do_wr(v[17:16], v[15:8]);
      else begin
        do_rd(v[17:16], b);
        chk($sformatf("table row %0d", k), 32'(b), 32'(v[7:0]));
      end
    end

    // R2 modes driven from command bytes
    chk("R2 ch_mode", 32'(ch_mode), {23'd0, 3'd3, 3'd1, 3'd2});

    // R13 rdata holds between reads
    repeat (2) @(negedge clk);
    chk("R13 rdata hold", 32'(rdata), 32'h34);

    // R3 low-byte load
    do_wr(2'd1, 8'h77);
    chk("R3 load pulse", 32'(ch_load), 32'h2);
    chk("R3 count", 32'(ch_count[31:16]), 32'h0077);
    @(negedge clk);
    chk("R13 load single cycle", 32'(ch_load), 32'h0);

    // R4 high-byte load
    do_wr(2'd2, 8'h66);
    chk("R4 load pulse", 32'(ch_load), 32'h4);
    chk("R4 count", 32'(ch_count[47:32]), 32'h6600);

    // R5 two-byte load
    do_wr(2'd0, 8'h11);
    chk("R5 no load after first byte", 32'(ch_load), 32'h0);
    do_wr(2'd0, 8'h22);
    chk("R5 load pulse", 32'(ch_load), 32'h1);
    chk("R5 count", 32'(ch_count[15:0]), 32'h2211);

    // R6 command rewinds write and read order
    do_wr(2'd0, 8'h55);
    do_wr(2'd3, 8'h34);
    do_wr(2'd0, 8'h33);
    chk("R6 first byte after rewind", 32'(ch_load), 32'h0);
    do_wr(2'd0, 8'h44);
    chk("R6 count", 32'(ch_count[15:0]), 32'h4433);
    do_rd(2'd0, b);
    chk("R6 read low", 32'(b), 32'h34);
    do_wr(2'd3, 8'h34);
    do_rd(2'd0, b);
    chk("R6 read order rewound", 32'(b), 32'h34);

    // R7 freeze once
    ch_live[15:0] = 16'h1111;
    do_wr(2'd3, 8'h00);
    ch_live[15:0] = 16'h2233;
    do_wr(2'd3, 8'h00);
    do_rd(2'd0, b);
    chk("R7 frozen low", 32'(b), 32'h11);
    do_rd(2'd0, b);
    chk("R7 frozen high kept", 32'(b), 32'h11);
    do_rd(2'd0, b);
    chk("R8 released to live", 32'(b), 32'h22);

    // R8 single-byte release
    ch_live[31:16] = 16'h00AA;
    do_wr(2'd3, 8'h40);
    ch_live[31:16] = 16'h00BB;
    do_rd(2'd1, b);
    chk("R8 frozen single", 32'(b), 32'hAA);
    do_rd(2'd1, b);
    chk("R8 released after one", 32'(b), 32'hBB);

    // R11 pending status not replaced
    do_wr(2'd3, 8'hE2);
    ch_out = 3'b100;
    do_wr(2'd3, 8'hE2);
    do_rd(2'd0, b);
    chk("R11 status kept", 32'(b), 32'hB4);
    do_rd(2'd0, b);
    chk("R12 status cleared", 32'(b), 32'h33);

    // R10 snapshot of all channels
    ch_out = 3'b011;
    do_wr(2'd3, 8'hCE);
    ch_live[31:16] = 16'h00CC;
    do_rd(2'd1, b);
    chk("R10 ch1 status", 32'(b), 32'h92);
    do_rd(2'd1, b);
    chk("R10 ch1 frozen", 32'(b), 32'hBB);
    do_rd(2'd1, b);
    chk("R12 ch1 live", 32'(b), 32'hCC);
    do_rd(2'd2, b);
    chk("R10 ch2 status", 32'(b), 32'h27);
    do_rd(2'd2, b);
    chk("R10 ch2 frozen", 32'(b), 32'h5A);
    do_rd(2'd0, b);
    chk("R10 ch0 status", 32'(b), 32'hB4);
    do_rd(2'd0, b);
    chk("R10 ch0 frozen low", 32'(b), 32'h33);
    do_rd(2'd0, b);
    chk("R10 ch0 frozen high", 32'(b), 32'h22);

    // R1 read ignored while writing
    @(negedge clk);
    addr = 2'd0; wdata = 8'h99; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R1 read ignored under write", 32'(rdata), 32'h22);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule